// File: doc/BRIEF.md
# Wake Event PME Signal Generator

This block converts wakeup events from a network controller into a power-management-event indication on a single output pin. A six-bit configuration field, taken from the upper bits of a flag byte, turns the function on or off and picks the signalling scheme: a held level or a timed pulse, a short or a long pulse, active-high or active-low, single-sided or push-pull drive, and whether WOL events or a PHY link-up event should wake the host.

Four event strobes feed the block: magic packet, perfect destination-address match, PHY link up and an external wakeup pin. A three-bit mask picks which WOL sources count. The block drives a pin value and a separate output-enable, so open-drain, open-source and push-pull pads can all be modelled by the pad outside. A level assertion is held until the host acknowledges it. Pulse lengths are counted in clock cycles derived from the `CLK_HZ` parameter: 1.5 ms and 150 ms of that clock.

Top module: `pme_wake_gen`

## Requirements
- R1: After reset, and from the edge at which a configuration with bit 7 (enable) = 0 is written, pme_oe = 0 and pme_out = 0, and no event changes either.
- R2: With bit 6 (mode) = 0, an accepted event asserts the output from the clock edge at which it is sampled, and the assertion holds until an ack pulse clears it at the next edge.
- R3: With bit 6 = 1, an accepted event asserts the output for exactly SHORT_CYC = 3*CLK_HZ/2000 cycles when bit 5 (length) = 0, or LONG_CYC = 3*CLK_HZ/20 cycles when bit 5 = 1; further events and ack during the pulse neither extend nor shorten it.
- R4: With bit 3 (drive) = 0, pme_oe = 1 only while asserted, and pme_out always equals bit 4 (polarity): polarity 0 is open-drain, polarity 1 is open-source.
- R5: With bit 3 = 1 and the block enabled, pme_oe = 1 on every cycle and pme_out equals bit 4 while asserted and its inverse otherwise.
- R6: With bit 2 (trigger class) = 0, an event counts only if its mask bit is 1 (mask bit 0 magic packet, bit 1 destination-address match, bit 2 wakeup pin); link up is ignored.
- R7: With bit 2 = 1, only the link-up strobe asserts the output; the other three sources are ignored whatever the mask.
- R8: Every configuration write ends any assertion in progress (level or pulse) at the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the configuration field |
| cfg_flags | input | 6 | Flag byte bits 7..2: enable, mode, length, polarity, drive, trigger class |
| wol_mask | input | 3 | WOL source enables: bit 0 magic, bit 1 address match, bit 2 wakeup pin |
| ev_magic | input | 1 | Magic packet received strobe |
| ev_addr_match | input | 1 | Perfect destination-address match strobe |
| ev_link_up | input | 1 | PHY link-up strobe |
| ev_wake_pin | input | 1 | Wakeup pin asserted strobe |
| ack | input | 1 | Host acknowledge, clears a level assertion |
| pme_out | output | 1 | Pin value |
| pme_oe | output | 1 | Pin output-enable |

## Verification
On every cycle the assertions hold the drive encoding (push-pull always enabled, single-sided output pinned to the polarity), the release after a disabling write, the persistence of a level assertion without ack, the silence of link-up mode without a link event, and an upper bound on every pulse length. Only the bench scenarios show the exact pulse widths for both lengths, that retriggers and ack leave a running pulse unchanged, that each masked source is gated in both trigger classes, and that an assertion starts on the expected edge.

// File: rtl/pme_pkg.sv
package pme_pkg;

  // Upper six bits of the flag byte, most significant first.
  typedef struct packed {
    logic en;        // bit 7: master enable
    logic pulse;     // bit 6: 0 level, 1 pulse
    logic long_len;  // bit 5: 0 short pulse, 1 long pulse
    logic pol;       // bit 4: 0 active low, 1 active high
    logic pp;        // bit 3: 0 single-sided, 1 push-pull
    logic link;      // bit 2: 0 WOL sources, 1 link-up only
  } pme_cfg_t;

  localparam int NUM_WOL = 3;

  function automatic int short_cycles(input int hz);
    return (hz / 2000) * 3;
  endfunction

  function automatic int long_cycles(input int hz);
    return (hz / 20) * 3;
  endfunction

endpackage

// File: rtl/pme_rst_sync.sv
module pme_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/pme_cfg_reg.sv
module pme_cfg_reg
  import pme_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [5:0] wr_data,
  output pme_cfg_t cfg
);

  pme_cfg_t cfg_n;

  always_comb begin
    cfg_n = cfg;
    if (wr_en) cfg_n = pme_cfg_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_n;
  end

endmodule

// File: rtl/pme_trigger.sv
module pme_trigger
  import pme_pkg::*;
(
  input  pme_cfg_t           cfg,
  input  logic [NUM_WOL-1:0] mask,
  input  logic               ev_magic,
  input  logic               ev_addr_match,
  input  logic               ev_link_up,
  input  logic               ev_wake_pin,
  output logic               trig
);

  logic [NUM_WOL-1:0] wol_ev;
  logic [NUM_WOL-1:0] wol_hit;

  assign wol_ev = {ev_wake_pin, ev_addr_match, ev_magic};

  for (genvar g = 0; g < NUM_WOL; g++) begin : g_gate
    assign wol_hit[g] = wol_ev[g] & mask[g];
  end

  always_comb begin
    trig = 1'b0;
    if (cfg.en) begin
      if (cfg.link) trig = ev_link_up;
      else          trig = |wol_hit;
    end
  end

endmodule

// File: rtl/pme_assert_ctl.sv
module pme_assert_ctl
  import pme_pkg::*;
#(
  parameter int SHORT_CYC = 30,
  parameter int LONG_CYC  = 3000,
  localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pme_cfg_t cfg,
  input  logic     clr,
  input  logic     trig,
  input  logic     ack,
  output logic     active
);

  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (clr) begin
      act_n = 1'b0;
      cnt_n = '0;
    end else if (cfg.pulse) begin
      if (act_q) begin
        if (cnt_q == '0) act_n = 1'b0;
        else             cnt_n = cnt_q - 1'b1;
      end else if (trig) begin
        act_n = 1'b1;
        cnt_n = cfg.long_len ? LONG_LD : SHORT_LD;
      end
    end else begin
      if (trig)     act_n = 1'b1;
      else if (ack) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/pme_pad_drive.sv
module pme_pad_drive
  import pme_pkg::*;
(
  input  pme_cfg_t cfg,
  input  logic     active,
  output logic     pin,
  output logic     oe
);

  always_comb begin
    pin = 1'b0;
    oe  = 1'b0;
    if (cfg.en) begin
      if (cfg.pp) begin
        oe  = 1'b1;
        pin = active ? cfg.pol : ~cfg.pol;
      end else begin
        oe  = active;
        pin = cfg.pol;
      end
    end
  end

endmodule

// File: rtl/pme_wake_gen.sv
module pme_wake_gen
  import pme_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [5:0] cfg_flags,
  input  logic [2:0] wol_mask,
  input  logic       ev_magic,
  input  logic       ev_addr_match,
  input  logic       ev_link_up,
  input  logic       ev_wake_pin,
  input  logic       ack,
  output logic       pme_out,
  output logic       pme_oe
);

  localparam int SHORT_CYC = short_cycles(CLK_HZ);
  localparam int LONG_CYC  = long_cycles(CLK_HZ);

  logic     rst_sync_n;
  pme_cfg_t cfg_q;
  logic     trig;
  logic     active;
  logic     clr;

  pme_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pme_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_flags),
    .cfg     (cfg_q)
  );

  pme_trigger u_trig (
    .cfg           (cfg_q),
    .mask          (wol_mask),
    .ev_magic      (ev_magic),
    .ev_addr_match (ev_addr_match),
    .ev_link_up    (ev_link_up),
    .ev_wake_pin   (ev_wake_pin),
    .trig          (trig)
  );

  assign clr = cfg_wr | ~cfg_q.en;

  pme_assert_ctl #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cfg    (cfg_q),
    .clr    (clr),
    .trig   (trig),
    .ack    (ack),
    .active (active)
  );

  pme_pad_drive u_pad (
    .cfg    (cfg_q),
    .active (active),
    .pin    (pme_out),
    .oe     (pme_oe)
  );

endmodule

// File: rtl/pme_wake_gen_chk.sv
module pme_wake_gen_chk
  import pme_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [5:0] cfg_flags,
  input logic       ev_link_up,
  input logic       ack,
  input logic       pme_out,
  input logic       pme_oe,
  input pme_cfg_t   cfg_q
);

  localparam int SHORT_CYC = short_cycles(CLK_HZ);
  localparam int LONG_CYC  = long_cycles(CLK_HZ);

  logic asrt;
  int   run_q;

  assign asrt = cfg_q.en && pme_oe && (pme_out == cfg_q.pol);

  // Length of the current pulse-mode assertion, counted independently.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= 0;
    else if (cfg_wr)                     run_q <= 0;
    else if (asrt && cfg_q.pulse)        run_q <= run_q + 1;
    else                                 run_q <= 0;
  end

  p_disable_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_flags[5]) |=> (!pme_oe && !pme_out));

  p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (asrt && !cfg_q.pulse && !ack && !cfg_wr) |=> asrt);

  p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (cfg_q.long_len ? LONG_CYC : SHORT_CYC));

  p_single_side_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_oe && !cfg_q.pp) |-> (pme_out == cfg_q.pol));

  p_push_pull_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.pp) |-> pme_oe);

  p_link_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.link && !asrt && !ev_link_up && !cfg_wr) |=> !asrt);

endmodule

bind pme_wake_gen pme_wake_gen_chk #(.CLK_HZ(CLK_HZ)) u_chk (.*);

// File: tb/tb_pme_wake_gen.sv
module tb_pme_wake_gen;

  localparam int CLK_HZ = 20_000;
  localparam int SHORT  = 30;
  localparam int LONG   = 3000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [5:0] cfg_flags;
  logic [2:0] wol_mask;
  logic       ev_magic, ev_addr_match, ev_link_up, ev_wake_pin;
  logic       ack;
  logic       pme_out, pme_oe;

  int   n_cmp = 0;
  int   n_bad = 0;
  logic [7:0] tb_cfg = 8'h00;
  int   exp_q[$];
  int   run = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  pme_wake_gen #(.CLK_HZ(CLK_HZ)) dut (
    .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_flags (cfg_flags),
    .wol_mask (wol_mask), .ev_magic (ev_magic), .ev_addr_match (ev_addr_match),
    .ev_link_up (ev_link_up), .ev_wake_pin (ev_wake_pin), .ack (ack),
    .pme_out (pme_out), .pme_oe (pme_oe)
  );

  task automatic chk(input string tag, input logic [1:0] exp);
    n_cmp++;
    if ({pme_oe, pme_out} !== exp) begin
      n_bad++;
      $display("FAIL %s {oe,out} actual=%b expected=%b at %0t", tag, {pme_oe, pme_out}, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] b);
    cfg_flags = b[7:2];
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    tb_cfg = b;
  endtask

  // bits: {pin, link, addr, magic}
  task automatic fire(input logic [3:0] ev);
    {ev_wake_pin, ev_link_up, ev_addr_match, ev_magic} = ev;
    @(negedge clk);
    {ev_wake_pin, ev_link_up, ev_addr_match, ev_magic} = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // Scoreboard monitor: measures each assertion episode, compares with queued pulse widths.
  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1 && tb_cfg[7] && pme_oe === 1'b1 && pme_out === tb_cfg[4]) begin
      run++;
    end else if (run > 0) begin
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        n_cmp++;
        if (run != e) begin
          n_bad++;
          $display("FAIL R3 pulse width actual=%0d expected=%0d", run, e);
        end
      end
      run = 0;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_flags = '0; wol_mask = 3'b111;
    {ev_wake_pin, ev_link_up, ev_addr_match, ev_magic} = '0; ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R1 reset", 2'b00);

    // R1: disabled, other bits set
    wr_cfg(8'h5C);
    fire(4'b1111);
    chk("R1 disabled events", 2'b00);
    step(2);
    chk("R1 disabled later", 2'b00);

    // R2/R5: level, active high, push-pull
    wr_cfg(8'h98);
    chk("R5 idle inverse", 2'b10);
    fire(4'b0001);
    chk("R2 level asserted", 2'b11);
    step(20);
    chk("R2 level held", 2'b11);
    do_ack();
    chk("R2 ack clears", 2'b10);

    // R4: open-drain
    wr_cfg(8'h80);
    chk("R4 open-drain idle", 2'b00);
    fire(4'b0010);
    chk("R4 open-drain assert", 2'b10);
    do_ack();
    chk("R4 open-drain release", 2'b00);

    // R4: open-source
    wr_cfg(8'h90);
    fire(4'b1000);
    chk("R4 open-source assert", 2'b11);
    do_ack();
    chk("R4 open-source release", 2'b01);

    // R6: WOL gating
    wr_cfg(8'h98);
    wol_mask = 3'b001;
    fire(4'b0010); chk("R6 addr masked", 2'b10);
    fire(4'b1000); chk("R6 pin masked", 2'b10);
    fire(4'b0100); chk("R6 link ignored", 2'b10);
    fire(4'b0001); chk("R6 magic enabled", 2'b11);
    do_ack();
    wol_mask = 3'b110;
    fire(4'b0001); chk("R6 magic masked", 2'b10);
    fire(4'b0010); chk("R6 addr enabled", 2'b11);
    do_ack();
    fire(4'b1000); chk("R6 pin enabled", 2'b11);
    do_ack();

    // R7: link-up class
    wol_mask = 3'b111;
    wr_cfg(8'h9C);
    fire(4'b0001); chk("R7 magic ignored", 2'b10);
    fire(4'b0010); chk("R7 addr ignored", 2'b10);
    fire(4'b1000); chk("R7 pin ignored", 2'b10);
    fire(4'b0100); chk("R7 link asserts", 2'b11);

    // R8: rewrite clears level
    wr_cfg(8'h9C);
    chk("R8 write clears level", 2'b10);

    // R3: short pulse, retrigger and ack ignored
    wr_cfg(8'hD8);
    exp_q.push_back(SHORT);
    fire(4'b0001);
    chk("R3 short pulse start", 2'b11);
    step(10);
    fire(4'b0010);
    do_ack();
    chk("R3 pulse continues", 2'b11);
    step(30);
    chk("R3 short pulse ended", 2'b10);

    // R3: long pulse
    wr_cfg(8'hF8);
    exp_q.push_back(LONG);
    fire(4'b0001);
    step(LONG + 10);
    chk("R3 long pulse ended", 2'b10);

    // R3/R4: short pulse active low open-drain
    wr_cfg(8'hC0);
    exp_q.push_back(SHORT);
    fire(4'b1000);
    chk("R4 pulse open-drain", 2'b10);
    step(SHORT + 5);
    chk("R3 open-drain pulse ended", 2'b00);

    // R8/R1: disabling write aborts pulse
    wr_cfg(8'hD8);
    fire(4'b0001);
    step(5);
    chk("R8 pulse running", 2'b11);
    wr_cfg(8'h58);
    chk("R8 abort on disable", 2'b00);
    step(40);
    chk("R1 stays released", 2'b00);

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3 pending pulses actual=%0d expected=0", exp_q.size());
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule